// File: doc/BRIEF.md
# Stream Source with Packet Zero-Fill

This block sits on the stream-input side of a DMA engine. Each transfer request names a fixed count of beats. The block forwards that many beats from a ready/valid stream to a downstream buffer writer, and it always delivers the full count.

When the incoming packet ends early, the stream's end-of-packet marker arrives before the count runs out. From that point the block supplies all-zero beats until the count is met. While it does this, it keeps its stream-ready output low, so the next packet stays untouched in the source. A transfer that ends exactly on the end-of-packet beat needs no padding. A transfer that runs out mid-packet leaves the rest of that packet for the next transfer.

A build-time option enables start synchronisation. With the option on, a request can ask to wait for a stream beat that carries the user sync bit. Beats that arrive before that beat are consumed and dropped. With the option off, the sync request bit and the user bit are ignored. Each request also carries an end-of-buffer flag, which is reported together with the completion pulse.

Top module: `strm_pad_src`

## Requirements
- R1: After reset, req_ready is 1, while m_valid, s_ready and xfer_done are 0, even when s_valid is high.
- R2: A request accepted with req_beats_m1 = L yields exactly L+1 output handshakes. m_last is 1 on the final one and 0 on all others.
- R3: While the block is streaming, m_data equals s_data, m_valid follows s_valid and s_ready follows m_ready in the same cycle, with no register in the path.
- R4: If s_last is accepted on a beat other than the final one, every remaining beat of the transfer is presented with m_valid = 1 and m_data = 0.
- R5: s_ready stays 0 for the whole zero-fill period, so no stream beat is consumed during it.
- R6: If s_last falls on the final beat, no zero beats are inserted and the block is ready for a new request in the next cycle.
- R7: Zero beats advance one per cycle while m_ready is 1. While m_ready is 0, the current zero beat is held with m_last unchanged.
- R8: req_ready is 0 from the cycle after a request is accepted until its transfer completes. A request presented during zero-fill is not taken.
- R9: xfer_done is 1 for exactly one cycle, the cycle after the final handshake. In that cycle done_eob equals the req_eob value captured with the request.
- R10: With SYNC_EN = 1 and req_sync = 1, beats with s_user = 0 are consumed (s_ready = 1) and never reach the output. The first output beat is the first beat with s_user = 1.
- R11: With SYNC_EN = 0, req_sync and s_user have no effect on any output.
- R12: If a transfer ends on a beat without s_last, no padding is added and the remainder of the packet is left in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_beats_m1 | input | LEN_W | Transfer length in beats, minus one |
| req_eob | input | 1 | End-of-buffer flag for this transfer |
| req_sync | input | 1 | Wait for a sync-marked beat before starting (SYNC_EN only) |
| s_data | input | DATA_W | Stream data |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_last | input | 1 | Final beat of a packet |
| s_user | input | 1 | Sync marker on a beat (SYNC_EN only) |
| m_data | output | DATA_W | Beat toward the buffer |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_last | output | 1 | Final beat of the transfer |
| xfer_done | output | 1 | One-cycle completion pulse |
| done_eob | output | 1 | End-of-buffer flag of the completed transfer |

## Verification
The bench sweeps every transfer length from one to eight beats against every position of the end-of-packet marker. That covers an early marker (padding), a marker on the final beat (no padding) and no marker at all (the packet carries over). The three cases differ in how many zero beats appear and whether s_ready drops. A stall pattern on m_ready during padding, with a competing request pending, shows whether zero beats are held rather than skipped and whether the request is kept out. A second instance built without the sync option receives the sync request and marker on every sweep, and its outputs are compared with the main instance. A dedicated run with sync enabled shows that unmarked beats are discarded before the transfer begins.

// File: rtl/spz_pkg.sv
package spz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_PASS = 2'd2,
        ST_FILL = 2'd3
    } spz_state_e;

    typedef struct packed {
        spz_state_e state;
        logic       eob;
        logic       done;
        logic       done_eob;
    } spz_ctrl_s;

endpackage

// File: rtl/spz_beat_cnt.sv
module spz_beat_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             step,
    output logic             final_o
);

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign final_o = (cnt_q == '0);

endmodule

// File: rtl/spz_lane_mux.sv
module spz_lane_mux #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              zero,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = zero ? '0 : din[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/spz_ctrl.sv
module spz_ctrl
    import spz_pkg::*;
#(
    parameter bit SYNC_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_sync,
    input  logic req_eob,
    input  logic s_valid,
    input  logic s_last,
    input  logic s_user,
    input  logic m_ready,
    input  logic final_i,
    output logic req_ready,
    output logic s_ready,
    output logic m_valid,
    output logic m_last,
    output logic fill_o,
    output logic load_o,
    output logic step_o,
    output logic done_o,
    output logic done_eob_o
);

    spz_ctrl_s st_d, st_q;
    logic      fire;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        req_ready = 1'b0;
        s_ready   = 1'b0;
        m_valid   = 1'b0;
        fill_o    = 1'b0;
        load_o    = 1'b0;

        case (st_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load_o     = 1'b1;
                    st_d.eob   = req_eob;
                    st_d.state = (SYNC_EN && req_sync) ? ST_SYNC : ST_PASS;
                end
            end
            ST_SYNC: begin
                if (s_user) begin
                    m_valid = s_valid;
                    s_ready = m_ready;
                end else begin
                    s_ready = 1'b1;
                end
            end
            ST_PASS: begin
                m_valid = s_valid;
                s_ready = m_ready;
            end
            default: begin
                m_valid = 1'b1;
                fill_o  = 1'b1;
            end
        endcase

        fire = m_valid && m_ready;

        if (fire) begin
            if (final_i) begin
                st_d.state    = ST_IDLE;
                st_d.done     = 1'b1;
                st_d.done_eob = st_q.eob;
            end else if (!fill_o && s_last) begin
                st_d.state = ST_FILL;
            end else if (st_q.state == ST_SYNC) begin
                st_d.state = ST_PASS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, eob: 1'b0, done: 1'b0, done_eob: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o     = fire;
    assign m_last     = m_valid && final_i;
    assign done_o     = st_q.done;
    assign done_eob_o = st_q.done_eob;

endmodule

// File: rtl/strm_pad_src.sv
module strm_pad_src #(
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter bit SYNC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LEN_W-1:0]  req_beats_m1,
    input  logic              req_eob,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_last,
    input  logic              s_user,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_last,
    output logic              xfer_done,
    output logic              done_eob
);

    localparam int LANE_W = (DATA_W % 8 == 0) ? 8 : DATA_W;

    logic final_w;
    logic fill_w;
    logic load_w;
    logic step_w;

    spz_ctrl #(
        .SYNC_EN (SYNC_EN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_sync   (req_sync),
        .req_eob    (req_eob),
        .s_valid    (s_valid),
        .s_last     (s_last),
        .s_user     (s_user),
        .m_ready    (m_ready),
        .final_i    (final_w),
        .req_ready  (req_ready),
        .s_ready    (s_ready),
        .m_valid    (m_valid),
        .m_last     (m_last),
        .fill_o     (fill_w),
        .load_o     (load_w),
        .step_o     (step_w),
        .done_o     (xfer_done),
        .done_eob_o (done_eob)
    );

    spz_beat_cnt #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .load_val (req_beats_m1),
        .step     (step_w),
        .final_o  (final_w)
    );

    spz_lane_mux #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_mux (
        .zero (fill_w),
        .din  (s_data),
        .dout (m_data)
    );

endmodule

// File: rtl/spz_chk.sv
module spz_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              s_ready,
    input logic              s_valid,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_last,
    input logic              xfer_done
);

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> xfer_done); // R9

    AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(m_valid && m_ready && m_last)); // R9

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && m_valid)); // R8

    AST_TAKEN_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_STALLED_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !s_ready) |-> (m_data == '0)); // R4

    AST_HELD_FILL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !s_ready) |=> (m_valid && $stable(m_last))); // R7

endmodule

bind strm_pad_src spz_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .s_ready   (s_ready),
    .s_valid   (s_valid),
    .m_data    (m_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_last    (m_last),
    .xfer_done (xfer_done)
);

// File: tb/strm_pad_src_test.sv
module strm_pad_src_test;

    localparam int DW = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_beats_m1 = '0;
    logic          req_eob = 1'b0;
    logic          req_sync = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_last = 1'b0;
    logic          s_user = 1'b0;
    logic          m_ready = 1'b1;

    logic          req_ready, s_ready, m_valid, m_last, xfer_done, done_eob;
    logic [DW-1:0] m_data;
    logic          ns_req_ready, ns_s_ready, ns_m_valid, ns_m_last, ns_done, ns_eob;
    logic [DW-1:0] ns_m_data;

    int n_tot = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    strm_pad_src #(.DATA_W(DW), .LEN_W(LW), .SYNC_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_beats_m1(req_beats_m1), .req_eob(req_eob), .req_sync(req_sync),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
        .s_user(s_user), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_last(m_last), .xfer_done(xfer_done), .done_eob(done_eob)
    );

    // Sync option off; sync request always raised to show it is ignored
    strm_pad_src #(.DATA_W(DW), .LEN_W(LW), .SYNC_EN(1'b0)) uut_ns (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ns_req_ready),
        .req_beats_m1(req_beats_m1), .req_eob(req_eob), .req_sync(1'b1),
        .s_data(s_data), .s_valid(s_valid), .s_ready(ns_s_ready), .s_last(s_last),
        .s_user(s_user), .m_data(ns_m_data), .m_valid(ns_m_valid), .m_ready(m_ready),
        .m_last(ns_m_last), .xfer_done(ns_done), .done_eob(ns_eob)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            finish_run();
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
        req_sync = 1'b0; m_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic compare_ns();
        chk("R11 ns m_valid", int'(ns_m_valid), int'(m_valid));
        chk("R11 ns m_data", int'(ns_m_data), int'(m_data));
        chk("R11 ns s_ready", int'(ns_s_ready), int'(s_ready));
    endtask

    // One transfer of len+1 beats; s_last on beat tp (tp > len: none)
    task automatic run_xfer(input int len, input int tp, input bit eob);
        req_valid = 1'b1; req_beats_m1 = LW'(len); req_eob = eob;
        #1 chk("R6 req_ready idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1 chk("R8 req_ready busy", int'(req_ready), 0);
        for (int i = 0; i <= len; i++) begin
            s_valid = 1'b1;
            if (i <= tp) begin
                s_data = DW'(16 * len + i + 1);
                s_last = (i == tp);
            end else begin
                s_data = 8'hA5;
                s_last = 1'b0;
            end
            #1;
            chk("R2 m_valid", int'(m_valid), 1);
            chk("R2 m_last", int'(m_last), int'(i == len));
            if (i <= tp) begin
                chk("R3 pass data", int'(m_data), 16 * len + i + 1);
                chk("R3 s_ready follows", int'(s_ready), 1);
            end else begin
                chk("R4 zero data", int'(m_data), 0);
                chk("R5 s_ready low", int'(s_ready), 0);
            end
            compare_ns();
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        #1;
        chk("R9 done pulse", int'(xfer_done), 1);
        chk("R9 done_eob", int'(done_eob), int'(eob));
        chk("R12 R6 ready after", int'(req_ready), 1);
        chk("R11 ns done", int'(ns_done), 1);
        @(negedge clk);
        #1 chk("R9 done one cycle", int'(xfer_done), 0);
    endtask

    initial begin
        s_valid = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 m_valid", int'(m_valid), 0);
        chk("R1 s_ready", int'(s_ready), 0);
        chk("R1 xfer_done", int'(xfer_done), 0);
        do_reset();
        s_valid = 1'b1;
        #1;
        chk("R1 s_ready idle", int'(s_ready), 0);
        chk("R1 m_valid idle", int'(m_valid), 0);
        s_valid = 1'b0;
        @(negedge clk);

        // Sweep lengths and packet-end positions (R2 R3 R4 R5 R6 R12)
        for (int len = 0; len < 8; len++) begin
            for (int tp = 0; tp <= len + 1; tp++) begin
                run_xfer(len, tp, bit'((len + tp) & 1));
            end
        end

        // R10: sync-gated start; R11: no-sync build ignores it
        do_reset();
        req_valid = 1'b1; req_beats_m1 = LW'(2); req_sync = 1'b1; req_eob = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 3; j++) begin
            s_valid = 1'b1; s_user = 1'b0; s_data = 8'h11; s_last = 1'b0;
            #1;
            chk("R10 drop s_ready", int'(s_ready), 1);
            chk("R10 drop m_valid", int'(m_valid), 0);
            chk("R11 ns passes", int'(ns_m_valid), 1);
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            s_valid = 1'b1; s_user = (i == 0); s_data = DW'(8'h30 + i);
            #1;
            chk("R10 sync m_valid", int'(m_valid), 1);
            chk("R10 sync data", int'(m_data), 8'h30 + i);
            chk("R10 sync m_last", int'(m_last), int'(i == 2));
            @(negedge clk);
        end
        s_valid = 1'b0; s_user = 1'b0; req_sync = 1'b0;
        #1;
        chk("R10 done", int'(xfer_done), 1);
        chk("R9 eob sync", int'(done_eob), 1);
        do_reset();

        // R7 R8: stall during padding with a request waiting
        req_valid = 1'b1; req_beats_m1 = LW'(4); req_eob = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        s_valid = 1'b1; s_data = 8'h42; s_last = 1'b1;
        #1 chk("R3 first beat", int'(m_data), 8'h42);
        @(negedge clk);
        s_data = 8'h99; s_last = 1'b0; m_ready = 1'b0; req_valid = 1'b1;
        for (int k = 0; k < 2; k++) begin
            #1;
            chk("R7 held valid", int'(m_valid), 1);
            chk("R7 held zero", int'(m_data), 0);
            chk("R7 held last", int'(m_last), 0);
            chk("R5 stall s_ready", int'(s_ready), 0);
            chk("R8 req blocked", int'(req_ready), 0);
            @(negedge clk);
        end
        m_ready = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            #1;
            chk("R7 fill m_last", int'(m_last), int'(i == 4));
            chk("R7 fill zero", int'(m_data), 0);
            chk("R8 req blocked fill", int'(req_ready), 0);
            if (i == 4) req_valid = 1'b0;
            @(negedge clk);
        end
        s_valid = 1'b0;
        #1;
        chk("R7 done after fill", int'(xfer_done), 1);
        chk("R8 ready after fill", int'(req_ready), 1);
        @(negedge clk);
        finish_run();
    end

endmodule